// File: doc/BRIEF.md
# Restartable Watchdog Interval Timer

This block measures fixed intervals against a slow timebase and reports each one that elapses. A 32.768 kHz clock-enable (`tick_32k`) feeds a prescaler. A 3-bit select picks one of seven timebase periods, or turns the timer off. An interval counter then counts `IVL_TICKS` timebase periods. When the interval ends, the block raises `tmr_out` for one timebase period and sets a sticky `tmr_flag`. It then reloads by itself and starts the next interval.

Software uses the block as a watchdog by pulsing `restart` before the interval runs out. A restart clears the whole count, clears the flag, and drops a pulse that is still in progress. An external enable, `chip_en`, freezes the whole timer state while it is low. When it goes high again, counting resumes from the point where it stopped.

Top module: `wdt_interval_timer`

## Requirements
- R1: After reset, `tmr_out` and `tmr_flag` are both 0.
- R2: With `tb_sel` = 0, the prescaler and interval count are cleared. `tmr_out` is 0 one cycle after any such edge, `tmr_flag` keeps its value, and no interval ever elapses.
- R3: A qualified tick is a cycle with `tick_32k`=1, `chip_en`=1, `tb_sel`≠0 and `restart`=0. With `tb_sel` = k (1..7), the timebase period is P = 4^(k-1) qualified ticks and the interval is L = `IVL_TICKS`·P qualified ticks (default `IVL_TICKS`=4). The edge that takes the n-th qualified tick since the last clear raises `tmr_out` when n is a multiple of L.
- R4: `tmr_out` stays high for exactly P qualified ticks and then falls. Counting continues with no software action, so with n qualified ticks counted, `tmr_out` = (n ≥ L and n mod L < P).
- R5: `tmr_flag` goes to 1 at the same edge as the first rise of `tmr_out` and stays at 1 until a restart.
- R6: `restart`=1 at an edge clears the count, `tmr_out` and `tmr_flag`, with priority over a tick arriving in the same cycle. The next interval needs a full L qualified ticks.
- R7: While `chip_en`=0 (and `tb_sel`≠0, `restart`=0), `tmr_out`, `tmr_flag` and the count hold. Cycles without `tick_32k` also leave everything unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_32k | input | 1 | One-cycle enable at the 32.768 kHz rate |
| tb_sel | input | 3 | Timebase select; 0 turns the timer off |
| restart | input | 1 | One-cycle restart write strobe |
| chip_en | input | 1 | High lets the timer count, low freezes it |
| tmr_out | output | 1 | Interval-elapsed pulse |
| tmr_flag | output | 1 | Sticky interval-elapsed flag |

## Verification
Both outputs are registered. Every input sampled at a clock edge therefore shows at the outputs right after that same edge, exactly one cycle after it is applied.

The bench drives inputs at the falling edge. At the next falling edge it compares the outputs against a model that counts qualified ticks since the last clear. The expected values come from the closed-form rule in R4, not from the structure of the prescaler.

Restarts that land mid-pulse, freezes and idle cycles are each checked on the first cycle after they are applied.

// File: rtl/wdt_timer_pkg.sv
// Package: shared sizing for the watchdog interval timer.
// Assumes the select field picks one of 2**SEL_W codes, with code 0 meaning off.
package wdt_timer_pkg;
    localparam int unsigned SEL_W   = 3;
    localparam int unsigned NUM_SEL = 1 << SEL_W;

    // Low-bit mask that marks a timebase boundary for a select code
    function automatic longint unsigned tap_mask(input int unsigned step, input int unsigned code);
        if (code == 0) return 64'd0;
        return (64'd1 << (step * (code - 1))) - 64'd1;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
// Module: tmr_prescaler
// Counts qualified input ticks. It emits a timebase tick on the qualified tick
// that completes each period of 2**(STEP*(sel-1)) ticks.
// Assumes the caller gates 'advance' with the enable and the clear condition.
module tmr_prescaler
    import wdt_timer_pkg::*;
#(
    parameter int unsigned STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             advance,
    input  logic [SEL_W-1:0] sel,
    output logic             tb_tick
);
    localparam int unsigned PRE_W = STEP * (NUM_SEL - 2);

    logic [PRE_W-1:0]   pre_cnt;
    logic [NUM_SEL-1:0] tap_hit;

    // Divider register: cleared on restart or off code, advanced per qualified tick
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (clear)   pre_cnt <= '0;
        else if (advance) pre_cnt <= pre_cnt + 1'b1;
    end

    // One boundary detector per select code; code 0 never fires
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
        if (g == 0) begin : g_off
            assign tap_hit[g] = 1'b0;
        end else begin : g_on
            localparam logic [PRE_W-1:0] MASK = PRE_W'(tap_mask(STEP, g));
            assign tap_hit[g] = ((pre_cnt & MASK) == MASK);
        end
    end

    assign tb_tick = advance & tap_hit[sel];
endmodule

// File: rtl/tmr_interval.sv
// Module: tmr_interval
// Counts timebase ticks and flags the tick that completes IVL_TICKS of them.
// After that tick it wraps to zero by itself.
// Assumes IVL_TICKS >= 2.
module tmr_interval #(
    parameter int unsigned IVL_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tb_tick,
    output logic elapse
);
    localparam int unsigned IVL_W = $clog2(IVL_TICKS);
    localparam logic [IVL_W-1:0] LAST = IVL_W'(IVL_TICKS - 1);

    logic [IVL_W-1:0] ivl_cnt;

    // Interval counter with automatic reload at the last timebase tick
    always_ff @(posedge clk) begin
        if (!rst_n)        ivl_cnt <= '0;
        else if (clear)    ivl_cnt <= '0;
        else if (tb_tick)  ivl_cnt <= (ivl_cnt == LAST) ? '0 : ivl_cnt + 1'b1;
    end

    assign elapse = tb_tick & (ivl_cnt == LAST);
endmodule

// File: rtl/tmr_output.sv
// Module: tmr_output
// Holds the interval pulse and the sticky flag.
// Restart has priority, then the off code, then elapse, then the end of the pulse.
// Assumes 'elapse' is only ever high together with 'tb_tick'.
module tmr_output (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel_off,
    input  logic tb_tick,
    input  logic elapse,
    output logic tmr_out,
    output logic tmr_flag
);
    // Pulse register: set on elapse, dropped on the next timebase tick
    always_ff @(posedge clk) begin
        if (!rst_n)        tmr_out <= 1'b0;
        else if (restart)  tmr_out <= 1'b0;
        else if (sel_off)  tmr_out <= 1'b0;
        else if (elapse)   tmr_out <= 1'b1;
        else if (tb_tick)  tmr_out <= 1'b0;
    end

    // Sticky flag: set on elapse, cleared only by restart
    always_ff @(posedge clk) begin
        if (!rst_n)        tmr_flag <= 1'b0;
        else if (restart)  tmr_flag <= 1'b0;
        else if (elapse)   tmr_flag <= 1'b1;
    end
endmodule

// File: rtl/wdt_interval_timer.sv
// Module: wdt_interval_timer (top)
// Restartable interval timer with a selectable timebase, a freeze enable and a watchdog restart.
// Assumes tick_32k and restart are single-cycle strobes synchronous to clk.
module wdt_interval_timer
    import wdt_timer_pkg::*;
#(
    parameter int unsigned STEP      = 2,
    parameter int unsigned IVL_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_32k,
    input  logic [SEL_W-1:0] tb_sel,
    input  logic             restart,
    input  logic             chip_en,
    output logic             tmr_out,
    output logic             tmr_flag
);
    logic sel_off;
    logic clear;
    logic advance;
    logic tb_tick;
    logic elapse;

    assign sel_off = (tb_sel == '0);
    assign clear   = restart | sel_off;
    assign advance = tick_32k & chip_en & ~clear;

    tmr_prescaler #(.STEP(STEP)) pre_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .advance (advance),
        .sel     (tb_sel),
        .tb_tick (tb_tick)
    );

    tmr_interval #(.IVL_TICKS(IVL_TICKS)) ivl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (clear),
        .tb_tick (tb_tick),
        .elapse  (elapse)
    );

    tmr_output out_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sel_off  (sel_off),
        .tb_tick  (tb_tick),
        .elapse   (elapse),
        .tmr_out  (tmr_out),
        .tmr_flag (tmr_flag)
    );
endmodule

// File: rtl/wdt_interval_timer_chk.sv
// Module: wdt_interval_timer_chk
// Temporal checks on the timer's ports, attached to every instance of the top module.
module wdt_interval_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_32k,
    input logic [2:0] tb_sel,
    input logic       restart,
    input logic       chip_en,
    input logic       tmr_out,
    input logic       tmr_flag
);
    // R6
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!tmr_out && !tmr_flag));

    // R2
    off_code_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tb_sel == 3'd0) |=> !tmr_out);

    // R7
    freeze_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_en && !restart && tb_sel != 3'd0) |=> ($stable(tmr_out) && $stable(tmr_flag)));

    // R7
    no_tick_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_32k && !restart && tb_sel != 3'd0) |=> ($stable(tmr_out) && $stable(tmr_flag)));

    // R5
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_flag && !restart) |=> tmr_flag);

    // R5
    rise_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_out) |-> tmr_flag);
endmodule

bind wdt_interval_timer wdt_interval_timer_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_32k (tick_32k),
    .tb_sel   (tb_sel),
    .restart  (restart),
    .chip_en  (chip_en),
    .tmr_out  (tmr_out),
    .tmr_flag (tmr_flag)
);

// File: tb/wdt_interval_timer_tb_top.sv
module wdt_interval_timer_tb_top;
    localparam int IVL = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [2:0] tb_sel = 3'd0;
    logic       restart = 1'b0;
    logic       chip_en = 1'b0;
    logic       tmr_out;
    logic       tmr_flag;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Model state: qualified ticks since the last clear, sticky flag, current code
    int n_m = 0;
    bit flag_m = 1'b0;
    int code_m = 0;

    always #5 clk = ~clk;

    wdt_interval_timer #(.STEP(2), .IVL_TICKS(IVL)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .tb_sel(tb_sel),
        .restart(restart), .chip_en(chip_en), .tmr_out(tmr_out), .tmr_flag(tmr_flag)
    );

    function automatic int period_of(input int code);
        return 1 << (2 * (code - 1));
    endfunction

    function automatic bit exp_out(input int n, input int code);
        int p;
        int l;
        if (code == 0) return 1'b0;
        p = period_of(code);
        l = IVL * p;
        return (n >= l) && ((n % l) < p);
    endfunction

    task automatic compare(input string req);
        bit eo;
        eo = exp_out(n_m, code_m);
        checks++;
        if (tmr_out !== eo || tmr_flag !== flag_m) begin
            failures++;
            $display("FAIL %s: out=%b flag=%b expected out=%b flag=%b (n=%0d code=%0d)",
                     req, tmr_out, tmr_flag, eo, flag_m, n_m, code_m);
        end
    endtask

    // One cycle: check what the previous edge produced, then apply and model new inputs
    task automatic step(input bit t, input bit ce, input int s, input bit rs, input string req);
        @(negedge clk);
        compare(req);
        tick_32k = t;
        chip_en  = ce;
        tb_sel   = 3'(s);
        restart  = rs;
        code_m   = s;
        if (rs) begin
            n_m = 0;
            flag_m = 1'b0;
        end else if (s == 0) begin
            n_m = 0;
        end else if (t && ce) begin
            n_m++;
            if (n_m % (IVL * period_of(s)) == 0) flag_m = 1'b1;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                failures++;
                $display("FAIL watchdog: out=%b flag=%b expected run to complete", tmr_out, tmr_flag);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        step(0, 1, 0, 0, "R1");
        // R2: off code with ticks never produces a pulse
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, "R2");
        // R3 R4 R5: code 1, tick every cycle
        step(0, 1, 1, 1, "R6");
        for (int i = 0; i < 40; i++) step(1, 1, 1, 0, "R3_R4_R5");
        // R3: code 3 with sparse ticks
        step(0, 1, 3, 1, "R6");
        for (int i = 0; i < 600; i++) step(($urandom % 3) != 0, 1, 3, 0, "R3");
        // R7: code 2 with random freezes and missing ticks
        step(0, 1, 2, 1, "R6");
        for (int i = 0; i < 800; i++) step($urandom % 2, ($urandom % 4) != 0, 2, 0, "R7");
        // R6: restart in the middle of a pulse, with a tick in the same cycle
        step(0, 1, 1, 1, "R6");
        for (int i = 0; i < 4; i++) step(1, 1, 1, 0, "R3");
        step(1, 1, 1, 1, "R6");
        for (int i = 0; i < 6; i++) step(1, 1, 1, 0, "R6");
        // R2: off code mid-run clears out, keeps flag
        for (int i = 0; i < 3; i++) step(1, 1, 0, 0, "R2");
        for (int i = 0; i < 20; i++) step(1, 1, 1, 0, "R2");
        // R3 boundary: slowest code
        step(0, 1, 7, 1, "R6");
        for (int i = 0; i < IVL * 4096 + 4096 + 20; i++) step(1, 1, 7, 0, "R3_R4");
        // R6 R7: random mix with watchdog restarts, code fixed between restarts
        for (int b = 0; b < 20; b++) begin
            int c = 1 + ($urandom % 3);
            step(1, 1, c, 1, "R6");
            for (int i = 0; i < 150; i++)
                step(($urandom % 4) != 0, ($urandom % 5) != 0, c, 0, "R7");
        end
        step(0, 1, 1, 0, "R7");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule